// File: doc/BRIEF.md
# Idle Mode Power Controller

This block decides when the processor core of a small 8-bit microcontroller may advance. It holds an 8-bit power-control register. Setting bit 0 of that register puts the core into idle: the block drops a registered CPU clock enable. The CPU state, including the program counter, the registers and the port output latches, is frozen because it only updates when the enable is high. Interrupt, timer, watchdog, divider, comparator and signal-detection logic do not use this enable and keep running.

Idle ends when any pending interrupt whose enable-mask bit is set is seen, or when reset is applied. On wake-up the hardware clears bit 0 and brings the clock enable back. Bit 4 selects what happens to the interrupt that caused the wake-up:
- With bit 4 at 0, the block issues a one-cycle take strobe with the index of the winning source, so the core runs the service routine. It then resumes after the instruction that entered idle.
- With bit 4 at 1, idle is simply released. The pending flag is left for normal interrupt arbitration.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: After a synchronous reset, `cpu_clk_en` is 1, `pctl_rdata` is 0x00 and `take_irq` is 0.
- R2: In run mode, a write of a byte with bit 0 set is visible on `pctl_rdata` one cycle later. `cpu_clk_en` stays 1 in that cycle and is 0 from the next cycle on, provided no wake condition is present.
- R3: While idle, a pending source whose enable bit is 0 does not end idle, and `cpu_clk_en` stays 0.
- R4: While idle, if any source has both its pending and enable bits at 1, then one cycle later `cpu_clk_en` is 1 and bit 0 of `pctl_rdata` reads 0. All other register bits keep their values.
- R5: When bit 4 is 0, the wake-up of R4 is accompanied by `take_irq` = 1 for exactly one cycle, in the same cycle in which `cpu_clk_en` returns. `take_idx` then gives the lowest-numbered source that is both pending and enabled.
- R6: When bit 4 is 1, the wake-up of R4 produces no `take_irq` pulse.
- R7: Bits other than 0 and 4 read back as written and have no effect on `cpu_clk_en` or `take_irq`.
- R8: A register write presented while idle is ignored, so the register keeps its value.
- R9: Reset applied while idle returns the block to the state of R1.
- R10: In run mode, `take_irq` stays 0 even when enabled interrupts are pending.
- R11: If the wake condition is already present in the first cycle after the idle-entering write, `cpu_clk_en` never drops. Bit 0 clears and R5/R6 apply one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| pctl_wr | input | 1 | Write strobe for the power-control register |
| pctl_wdata | input | 8 | Write data for the power-control register |
| irq_pend | input | NUM_IRQ | Pending flags of the interrupt sources |
| irq_en | input | NUM_IRQ | Enable mask of the interrupt sources |
| cpu_clk_en | output | 1 | Registered clock enable for the CPU core |
| take_irq | output | 1 | One-cycle strobe: service the wake-up interrupt |
| take_idx | output | IDX_W | Index of the source to service |
| pctl_rdata | output | 8 | Power-control register readback |

## Verification
The dangerous internal fault is a stale idle bit or a clock-enable register that is out of step with it. Such a fault shows within one cycle as a `cpu_clk_en` that stays high after an idle write, or that stays low after an enabled interrupt. The bench therefore checks the enable on the exact cycle after each write and after each wake-up. A wrong wake-mode decision shows as a `take_irq` pulse that is missing or unexpected on the wake cycle. A wrong priority shows as a wrong `take_idx`. The scoreboard catches both, because every wake-up either queues exactly one expected index or queues none.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  // register width and the two bit positions the core software decodes
  localparam int PCTL_W   = 8;
  localparam int IDLE_POS = 0;
  localparam int SKIP_POS = 4;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_IDLE = 1'b1
  } pmode_e;

  function automatic pmode_e mode_of(input logic [PCTL_W-1:0] r);
    return r[IDLE_POS] ? MODE_IDLE : MODE_RUN;
  endfunction
endpackage

// File: rtl/ipc_ctl_reg.sv
module ipc_ctl_reg
  import ipc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PCTL_W-1:0] wr_data,
  input  logic              wake,
  output pmode_e            mode_o,
  output logic              skip_o,
  output logic [PCTL_W-1:0] rdata_o
);
  logic [PCTL_W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (mode_of(q) == MODE_IDLE) begin
      if (wake) q[IDLE_POS] <= 1'b0;
    end else if (wr_en) begin
      q <= wr_data;
    end
  end

  assign mode_o  = mode_of(q);
  assign skip_o  = q[SKIP_POS];
  assign rdata_o = q;

  // R4
  wake_clears_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (q[IDLE_POS] && wake) |=> (!q[IDLE_POS] && $stable(q[PCTL_W-1:1])));

  // R8
  idle_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (q[IDLE_POS] && !wake) |=> $stable(q));
endmodule

// File: rtl/ipc_wake_det.sv
module ipc_wake_det #(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               idle_i,
  output logic               wake_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_IRQ-1:0] live;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_mask
    assign live[g] = irq_pend[g] & irq_en[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (live[i]) idx_o = IDX_W'(i);
    end
  end

  assign wake_o = idle_i & (|live);
endmodule

// File: rtl/ipc_seq.sv
module ipc_seq #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle_i,
  input  logic             wake_i,
  input  logic             skip_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             clk_en_o,
  output logic             take_o,
  output logic [IDX_W-1:0] take_idx_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en_o   <= 1'b1;
      take_o     <= 1'b0;
      take_idx_o <= '0;
    end else begin
      clk_en_o <= !(idle_i && !wake_i);
      take_o   <= wake_i && !skip_i;
      if (wake_i) take_idx_o <= idx_i;
    end
  end

  // R2
  en_drop_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en_o) |-> $past(idle_i && !wake_i));

  // R4
  wake_restores_en_chk: assert property (@(posedge clk) disable iff (rst)
    wake_i |=> clk_en_o);

  // R10
  take_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(idle_i && wake_i));

  // R6
  skip_blocks_take_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !$past(skip_i));

  // R5
  take_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);
endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
  import ipc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pctl_wr,
  input  logic [PCTL_W-1:0]  pctl_wdata,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               cpu_clk_en,
  output logic               take_irq,
  output logic [IDX_W-1:0]   take_idx,
  output logic [PCTL_W-1:0]  pctl_rdata
);
  pmode_e           mode;
  logic             skip;
  logic             wake;
  logic [IDX_W-1:0] win_idx;

  ipc_ctl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (pctl_wr),
    .wr_data (pctl_wdata),
    .wake    (wake),
    .mode_o  (mode),
    .skip_o  (skip),
    .rdata_o (pctl_rdata)
  );

  ipc_wake_det #(.NUM_IRQ(NUM_IRQ)) u_det (
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .idle_i   (mode == MODE_IDLE),
    .wake_o   (wake),
    .idx_o    (win_idx)
  );

  ipc_seq #(.IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .idle_i     (mode == MODE_IDLE),
    .wake_i     (wake),
    .skip_i     (skip),
    .idx_i      (win_idx),
    .clk_en_o   (cpu_clk_en),
    .take_o     (take_irq),
    .take_idx_o (take_idx)
  );

  // R5
  take_idx_live_chk: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> ((($past(irq_pend & irq_en) >> take_idx) & 1) != 0));
endmodule

// File: tb/idle_pwr_ctrl_tb.sv
module idle_pwr_ctrl_tb;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pctl_wr = 1'b0;
  logic [7:0] pctl_wdata = '0;
  logic [N-1:0] irq_pend = '0;
  logic [N-1:0] irq_en = '0;
  logic       cpu_clk_en;
  logic       take_irq;
  logic [2:0] take_idx;
  logic [7:0] pctl_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #10 clk = ~clk;

  idle_pwr_ctrl #(.NUM_IRQ(N)) u_dut (
    .clk(clk), .rst(rst), .pctl_wr(pctl_wr), .pctl_wdata(pctl_wdata),
    .irq_pend(irq_pend), .irq_en(irq_en), .cpu_clk_en(cpu_clk_en),
    .take_irq(take_irq), .take_idx(take_idx), .pctl_rdata(pctl_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // monitor: pops expected take indices from the scoreboard
  always @(negedge clk) begin
    if (!rst && take_irq) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5/R6/R10 unexpected take actual=%0d expected=none", take_idx);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(take_idx) != e) begin
          fails++;
          $display("FAIL R5 take_idx actual=%0d expected=%0d", take_idx, e);
        end
      end
    end
  end

  // write a byte with bit 0 set and confirm entry into idle (R2)
  task automatic enter_idle(input logic [7:0] v);
    pctl_wr = 1'b1; pctl_wdata = v;
    step();
    pctl_wr = 1'b0;
    check("R2 readback", pctl_rdata, v);
    check("R2 en still high", cpu_clk_en, 1);
    step();
    check("R2 en low", cpu_clk_en, 0);
  endtask

  // raise an enabled interrupt while idle; push expected index if serviced
  task automatic wake(input logic [N-1:0] p, input logic [N-1:0] m,
                      input logic [7:0] regv, input int idx);
    irq_pend = p; irq_en = m;
    if (!regv[4]) exp_q.push_back(idx);
    step();
    check("R4 en back", cpu_clk_en, 1);
    check("R4 idle bit cleared", pctl_rdata, regv & 8'hFE);
    if (regv[4]) check("R6 no take", take_irq, 0);
    else check("R5 take pulse", take_irq, 1);
    step();
    check("R5 pulse one cycle", take_irq, 0);
    irq_pend = '0;
  endtask

  initial begin
    repeat (3) step();
    check("R1 en", cpu_clk_en, 1);
    check("R1 reg", pctl_rdata, 0);
    check("R1 take", take_irq, 0);
    rst = 1'b0;
    step();

    // R2, R3, R4, R5: serviced wake, lowest enabled index wins
    enter_idle(8'h01);
    irq_pend = 8'h28; irq_en = 8'h00;
    repeat (4) step();
    check("R3 masked keeps idle", cpu_clk_en, 0);
    check("R3 reg unchanged", pctl_rdata, 8'h01);
    wake(8'h28, 8'h28, 8'h01, 3);

    // R5 with mask picking the higher source
    enter_idle(8'h01);
    wake(8'h28, 8'h20, 8'h01, 5);

    // R6: bit 4 set, wake without service
    enter_idle(8'h11);
    wake(8'h02, 8'hFF, 8'h11, 0);

    // R7: other bits read back and have no effect
    pctl_wr = 1'b1; pctl_wdata = 8'hA4;
    step();
    pctl_wr = 1'b0;
    check("R7 readback", pctl_rdata, 8'hA4);
    repeat (2) step();
    check("R7 en unaffected", cpu_clk_en, 1);

    // R10: enabled pending in run mode gives no take
    irq_pend = 8'h04; irq_en = 8'h04;
    repeat (3) step();
    check("R10 no take in run", take_irq, 0);

    // R11: wake already present right after the idle write
    pctl_wr = 1'b1; pctl_wdata = 8'h01;
    exp_q.push_back(2);
    step();
    pctl_wr = 1'b0;
    check("R11 readback", pctl_rdata, 8'h01);
    check("R11 en high", cpu_clk_en, 1);
    step();
    check("R11 en never drops", cpu_clk_en, 1);
    check("R11 idle cleared", pctl_rdata, 8'h00);
    check("R11 take", take_irq, 1);
    irq_pend = '0; irq_en = '0;
    step();

    // R8: write during idle ignored
    enter_idle(8'h01);
    pctl_wr = 1'b1; pctl_wdata = 8'hFE;
    step();
    pctl_wr = 1'b0;
    step();
    check("R8 reg kept", pctl_rdata, 8'h01);
    check("R8 still idle", cpu_clk_en, 0);
    wake(8'h80, 8'hFF, 8'h01, 7);

    // R9: reset while idle
    enter_idle(8'h91);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R9 en", cpu_clk_en, 1);
    check("R9 reg", pctl_rdata, 0);
    check("R9 take", take_irq, 0);
    step();

    check("R5 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule